// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog

This block is a watchdog timer for a processor subsystem. A free-running timebase counter advances on every clock. A separate interval counter measures windows of 2^N clock cycles, where N is a build-time parameter. The first window that ends without a keepalive raises a warning flag and drives an interrupt level. If the warning flag is still set when the next window ends, the block emits a reset pulse of a parameterised length and latches a sticky record of that event. Software can read this record after the system restarts.

Software reaches the block through a simple 32-bit register port with three words. Two control words each hold one enable bit, and the watchdog counts only while both bits are 1. This makes an accidental stop by a single stray write less likely. The third word returns the live timebase value. The keepalive action is a write of 1 to the warning flag. The same write also restarts the interval.

Top module: `twostage_wdog`

## Requirements
- R1: After power-on reset, the words at offsets 0x0 and 0x4 read 0, and both `irq_o` and `wdt_rst_o` are low.
- R2: Reads are combinational while `bus_sel_i` is high. The word at 0x0 carries the reset-seen flag in bit 3, the warning flag in bit 2 and enable A in bit 1, with all other bits 0. The word at 0x4 carries enable B in bit 0. The word at 0x8 is the timebase. Any other offset reads 0.
- R3: With only one of enable A and enable B set, no expiry happens, however long the block waits.
- R4: The warning flag and `irq_o` rise exactly 2^N cycles after the clock edge that makes both enables 1.
- R5: If the warning flag is still set when the next 2^N-cycle window ends, `wdt_rst_o` is high for exactly RST_CYCLES cycles, starting at that expiry edge.
- R6: A write to 0x0 with bit 2 set clears the warning flag and restarts the interval from zero, whether or not the flag was set. Writing 0 to bit 2 or bit 3 leaves that flag unchanged.
- R7: The reset-seen flag is set by the reset pulse and stays set after the pulse ends. Only a write of 1 to bit 3 of 0x0, or power-on reset, clears it.
- R8: The timebase increases by one every clock, so reads on two consecutive cycles differ by exactly 1.
- R9: Clearing either enable stops the interval counter. Re-enabling restarts the count from zero, not from where it stopped.
- R10: A keepalive write whose clock edge coincides with the end of a window cancels that expiry. The next expiry then comes 2^N cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle |
| irq_o | output | 1 | Interrupt level, follows the warning flag |
| wdt_rst_o | output | 1 | System reset pulse, RST_CYCLES long |

## Verification
The assertions check on every cycle that a reset pulse only begins while the warning is already raised, that a disabled block never raises a new warning, that a keepalive always leaves the warning clear, that the reset-seen flag drops only on a software clear, and that the timebase steps by one. Only the bench scenarios can show the exact expiry cycle counted from an enable or keepalive edge, and the exact reset pulse width. The same holds for restart-from-zero after a pause, cancellation of an expiry by a keepalive on the same edge, and the register encodings.

// File: rtl/twd_pkg.sv
`timescale 1ns/1ps
package twd_pkg;
   localparam int unsigned WORD_W     = 32;
   // byte offsets of the three words
   localparam int unsigned OFS_CTRL_A = 'h0;
   localparam int unsigned OFS_CTRL_B = 'h4;
   localparam int unsigned OFS_TBASE  = 'h8;
   // bit positions inside the control words
   localparam int unsigned B_RSEEN    = 3;
   localparam int unsigned B_WARN     = 2;
   localparam int unsigned B_EN_A     = 1;
   localparam int unsigned B_EN_B     = 0;

   // one-cycle commands from the register port to the expiry engine
   typedef struct packed {
      logic kick;     // clear warning, restart interval
      logic clr_seen; // clear reset-seen record
   } twd_cmd_t;
endpackage

// File: rtl/twd_timebase.sv
`timescale 1ns/1ps
module twd_timebase #(
   parameter int unsigned TB_W = 32
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   output logic [TB_W-1:0] tbase_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tbase_o <= '0;
      else         tbase_o <= tbase_o + 1'b1;
   end

   assert_tb_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> tbase_o == TB_W'($past(tbase_o) + 1'b1));
endmodule

// File: rtl/twd_expiry.sv
`timescale 1ns/1ps
module twd_expiry
   import twd_pkg::*;
#(
   parameter int unsigned INTERVAL_LOG2 = 6,
   parameter int unsigned RST_CYCLES    = 4
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     run_i,
   input  twd_cmd_t cmd_i,
   output logic     warn_o,
   output logic     seen_o,
   output logic     wdt_rst_o
);
   localparam int unsigned      CNT_W    = INTERVAL_LOG2;
   localparam logic [CNT_W-1:0] CNT_LAST = '1;

   logic [CNT_W-1:0] ivl_q;
   logic             tick;
   logic             fire;

   // a keepalive on the expiry edge wins over the expiry
   assign tick = run_i && !cmd_i.kick && (ivl_q == CNT_LAST);
   assign fire = tick && warn_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   ivl_q <= '0;
      else if (!run_i || cmd_i.kick) ivl_q <= '0;
      else                           ivl_q <= ivl_q + 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         warn_o <= 1'b0;
      else if (cmd_i.kick) warn_o <= 1'b0;
      else if (tick)       warn_o <= 1'b1;
   end

   // a set by the reset pulse wins over a software clear on the same edge
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             seen_o <= 1'b0;
      else if (fire)           seen_o <= 1'b1;
      else if (cmd_i.clr_seen) seen_o <= 1'b0;
   end

   generate
      if (RST_CYCLES == 1) begin : g_pulse_flop
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) wdt_rst_o <= 1'b0;
            else         wdt_rst_o <= fire;
         end
      end else begin : g_pulse_cnt
         localparam int unsigned PW = $clog2(RST_CYCLES + 1);
         logic [PW-1:0] left_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)              left_q <= '0;
            else if (fire)            left_q <= PW'(RST_CYCLES);
            else if (left_q != '0)    left_q <= left_q - 1'b1;
         end
         assign wdt_rst_o = (left_q != '0);

         assert_pulse_min_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(wdt_rst_o) |=> wdt_rst_o);
      end
   endgenerate

   assert_idle_no_warn_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> !$rose(warn_o));

   // R10: also covers a keepalive that lands on the expiry edge
   assert_kick_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_i.kick |=> !warn_o);

   assert_seen_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(seen_o) |-> $past(cmd_i.clr_seen));
endmodule

// File: rtl/twd_regif.sv
`timescale 1ns/1ps
module twd_regif
   import twd_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned TB_W   = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [WORD_W-1:0] bus_wdata_i,
   output logic [WORD_W-1:0] bus_rdata_o,
   input  logic              warn_i,
   input  logic              seen_i,
   input  logic [TB_W-1:0]   tbase_i,
   output twd_cmd_t          cmd_o,
   output logic              run_o
);
   logic hit_a, hit_b, hit_t;
   logic wr_a, wr_b;
   logic en_a_q, en_b_q;
   logic [WORD_W-1:0] tb_word;
   logic unused_wdata;

   assign hit_a = (bus_addr_i == ADDR_W'(OFS_CTRL_A));
   assign hit_b = (bus_addr_i == ADDR_W'(OFS_CTRL_B));
   assign hit_t = (bus_addr_i == ADDR_W'(OFS_TBASE));
   assign wr_a  = bus_sel_i && bus_wr_i && hit_a;
   assign wr_b  = bus_sel_i && bus_wr_i && hit_b;
   assign unused_wdata = ^bus_wdata_i;

   assign cmd_o.kick     = wr_a && bus_wdata_i[B_WARN];
   assign cmd_o.clr_seen = wr_a && bus_wdata_i[B_RSEEN];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   en_a_q <= 1'b0;
      else if (wr_a) en_a_q <= bus_wdata_i[B_EN_A];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   en_b_q <= 1'b0;
      else if (wr_b) en_b_q <= bus_wdata_i[B_EN_B];
   end

   assign run_o = en_a_q && en_b_q;

   generate
      if (TB_W == WORD_W) begin : g_tb_full
         assign tb_word = tbase_i;
      end else begin : g_tb_ext
         assign tb_word = {{(WORD_W-TB_W){1'b0}}, tbase_i};
      end
   endgenerate

   always_comb begin
      bus_rdata_o = '0;
      if (bus_sel_i && !bus_wr_i) begin
         if (hit_a) begin
            bus_rdata_o[B_RSEEN] = seen_i;
            bus_rdata_o[B_WARN]  = warn_i;
            bus_rdata_o[B_EN_A]  = en_a_q;
         end else if (hit_b) begin
            bus_rdata_o[B_EN_B]  = en_b_q;
         end else if (hit_t) begin
            bus_rdata_o = tb_word;
         end
      end
   end

   assert_enable_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_a && !bus_wdata_i[B_EN_A]) |=> !run_o);
endmodule

// File: rtl/twostage_wdog.sv
`timescale 1ns/1ps
module twostage_wdog
   import twd_pkg::*;
#(
   parameter int unsigned INTERVAL_LOG2 = 6,
   parameter int unsigned RST_CYCLES    = 4,
   parameter int unsigned TB_W          = 32,
   parameter int unsigned ADDR_W        = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   output logic              irq_o,
   output logic              wdt_rst_o
);
   generate
      if (INTERVAL_LOG2 < 2 || INTERVAL_LOG2 > 30) begin : g_bad_interval
         $error("INTERVAL_LOG2 must lie in 2..30");
      end
      if (RST_CYCLES < 1 || RST_CYCLES >= (1 << INTERVAL_LOG2)) begin : g_bad_pulse
         $error("RST_CYCLES must be at least 1 and shorter than one interval");
      end
      if (TB_W < 1 || TB_W > WORD_W) begin : g_bad_tb
         $error("TB_W must lie in 1..32");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("ADDR_W must be at least 4");
      end
   endgenerate

   twd_cmd_t        cmd;
   logic            run;
   logic            warn;
   logic            seen;
   logic [TB_W-1:0] tbase;

   twd_timebase #(.TB_W(TB_W)) u_tb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tbase_o (tbase)
   );

   twd_regif #(.ADDR_W(ADDR_W), .TB_W(TB_W)) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .bus_sel_i   (bus_sel_i),
      .bus_wr_i    (bus_wr_i),
      .bus_addr_i  (bus_addr_i),
      .bus_wdata_i (bus_wdata_i),
      .bus_rdata_o (bus_rdata_o),
      .warn_i      (warn),
      .seen_i      (seen),
      .tbase_i     (tbase),
      .cmd_o       (cmd),
      .run_o       (run)
   );

   twd_expiry #(.INTERVAL_LOG2(INTERVAL_LOG2), .RST_CYCLES(RST_CYCLES)) u_exp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run),
      .cmd_i     (cmd),
      .warn_o    (warn),
      .seen_o    (seen),
      .wdt_rst_o (wdt_rst_o)
   );

   assign irq_o = warn;

   assert_rst_after_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(wdt_rst_o) |-> $past(irq_o));
endmodule

// File: tb/tb_twostage_wdog.sv
`timescale 1ns/1ps
module tb_twostage_wdog;
   localparam int N    = 6;
   localparam int PER  = 1 << N;
   localparam int RSTW = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        sel, wr;
   logic [3:0]  addr;
   logic [31:0] wdata, rdata;
   logic        irq, wrst;

   always #2.5 clk = ~clk;

   twostage_wdog #(.INTERVAL_LOG2(N), .RST_CYCLES(RSTW), .TB_W(32), .ADDR_W(4)) dut (
      .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .wdt_rst_o(wrst)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int tests = 0;
   int fails = 0;
   bit done  = 0;

   typedef struct { int kind; int at; int width; string req; } exp_t;
   exp_t sbq[$];

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic push(input int kind, input int at, input string req);
      exp_t e;
      e.kind = kind; e.at = at; e.width = (kind == 1) ? RSTW : 0; e.req = req;
      sbq.push_back(e);
   endtask

   // monitor side of the scoreboard
   task automatic observe(input int kind, input int at, input int width);
      exp_t e;
      if (sbq.size() == 0) begin
         tests++; fails++;
         $display("FAIL R4 unexpected event kind=%0d actual_cycle=%0d expected=none", kind, at);
      end else begin
         e = sbq.pop_front();
         check({e.req, " kind"}, kind, e.kind);
         check({e.req, " cycle"}, at, e.at);
         if (kind == 1) check({e.req, " width"}, width, e.width);
      end
   endtask

   logic irq_d = 1'b0, rst_d = 1'b0;
   int   rst_start = 0;
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (irq && !irq_d) observe(0, cyc, 0);
         if (wrst && !rst_d) rst_start = cyc;
         if (!wrst && rst_d) observe(1, rst_start, cyc - rst_start);
      end
      irq_d = irq;
      rst_d = wrst;
   end

   // called at a negedge; returns at the next negedge with the write edge number
   task automatic bus_write(input logic [3:0] a, input logic [31:0] d, output int edge_no);
      sel = 1; wr = 1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      edge_no = cyc;
      sel = 0; wr = 0; wdata = '0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      sel = 1; wr = 0; addr = a;
      #1 d = rdata;
      sel = 0;
      @(negedge clk);
   endtask

   task automatic wait_until(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] v, ta, tb2;
      int e, k, k2, dummy;
      rst_n = 0; sel = 0; wr = 0; addr = '0; wdata = '0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      bus_read(4'h0, v); check("R1 ctrl A", v, 0);
      bus_read(4'h4, v); check("R1 ctrl B", v, 0);
      check("R1 outputs", {30'd0, wrst, irq}, 0);
      // R2 unmapped offset
      bus_read(4'hC, v); check("R2 unmapped", v, 0);
      // R8 timebase on consecutive cycles
      bus_read(4'h8, ta); bus_read(4'h8, tb2);
      check("R8 step", tb2 - ta, 1);

      // R3 only enable B
      bus_write(4'h4, 32'h1, dummy);
      bus_read(4'h4, v); check("R2 enable B bit0", v, 1);
      wait_until(cyc + 3*PER);
      check("R3 B only", irq, 0);
      // R3 only enable A
      bus_write(4'h4, 32'h0, dummy);
      bus_write(4'h0, 32'h2, dummy);
      bus_read(4'h0, v); check("R2 enable A bit1", v, 32'h2);
      wait_until(cyc + 3*PER);
      check("R3 A only", irq, 0);

      // R4/R5 two expiries without keepalive
      bus_write(4'h4, 32'h1, e);
      push(0, e + PER, "R4");
      push(1, e + 2*PER, "R5");
      wait_until(e + 2*PER + RSTW + 2);
      bus_read(4'h0, v); check("R7 seen kept after pulse", v, 32'hE);
      bus_write(4'h0, 32'h0, dummy);
      bus_read(4'h0, v); check("R6 zero writes keep flags", v, 32'hC);
      bus_write(4'h0, 32'h8, dummy);
      bus_read(4'h0, v); check("R7 clear seen", v, 32'h4);
      bus_write(4'h0, 32'h4, dummy);
      bus_read(4'h0, v); check("R6 clear warn", v, 0);
      check("R6 irq low", irq, 0);

      // R6 keepalive clears warning and restarts interval
      bus_write(4'h0, 32'h2, e);
      push(0, e + PER, "R4");
      wait_until(e + PER + 10);
      bus_write(4'h0, 32'h6, k);
      check("R6 irq cleared", irq, 0);
      wait_until(k + 30);
      bus_write(4'h0, 32'h6, k2);
      push(0, k2 + PER, "R6");
      wait_until(k2 + PER + 5);
      bus_read(4'h0, v); check("R6 warn after restart", v, 32'h6);
      check("R5 no pulse", wrst, 0);
      bus_write(4'h0, 32'h4, dummy);

      // R9 pause and resume from zero
      bus_write(4'h0, 32'h2, e);
      wait_until(e + 40);
      bus_write(4'h0, 32'h0, dummy);
      wait_until(cyc + 2*PER);
      check("R9 paused", irq, 0);
      bus_write(4'h0, 32'h2, e);
      push(0, e + PER, "R9");
      wait_until(e + PER + 3);
      check("R9 resumed", irq, 1);
      bus_write(4'h0, 32'h4, dummy);

      // R10 keepalive on the expiry edge
      bus_write(4'h0, 32'h2, e);
      wait_until(e + PER - 1);
      bus_write(4'h0, 32'h6, k);
      check("R10 edge align", k, e + PER);
      check("R10 expiry cancelled", irq, 0);
      push(0, k + PER, "R10");
      wait_until(k + PER + 2);
      check("R10 next expiry", irq, 1);
      bus_write(4'h0, 32'h4, dummy);
      bus_read(4'h0, v); check("R10 final state", v, 0);

      wait_until(cyc + 5);
      check("R5 scoreboard drained", sbq.size(), 0);
      finish_run();
   end
endmodule